// File: doc/BRIEF.md
# G.711 Companding Codec Stage

This block sits between a linear PCM audio datapath and a serial audio port. Its transmit direction turns each linear sample into an 8-bit logarithmic code, either A-law or μ-law, including the bit inversions the standard applies to the transmitted byte. The code is placed in the most significant byte of a wider audio slot. Its receive direction takes the top byte of an incoming slot and expands it back to a linear sample.

Each direction has its own enable and its own law select. Both are taken together with every sample, so the configuration can change between back-to-back samples. When a direction is disabled, linear data passes through it, aligned to the most significant end. A sample enters with a one-cycle valid strobe and appears on the output one clock later. The output register holds its value between samples.

Top module: `g711_codec_stage`

## Requirements
- R1: While reset is asserted, and until the first sample after reset, both output valids are 0 and both output words are all zeros.
- R2: With the transmit enable high and law select 1 (μ-law), the encoder uses the top 14 bits of the sample. It takes the magnitude, clamps it to 8159, adds 33, and forms {0, segment[2:0], mantissa[3:0]}. The segment is the position of the leading one minus 5, and the mantissa is the four bits just below the leading one. The byte is then XORed with 0xFF for a non-negative sample or with 0x7F for a negative one. A zero sample gives 0xFF.
- R3: With the transmit enable high and law select 0 (A-law), the encoder uses the top 13 bits of the sample. Its magnitude is the value itself, or the ones' complement for a negative sample. Segment 0 covers magnitudes up to 31 and takes its mantissa from magnitude bits [4:1]. Segment k≥1 takes bits [k+3:k]. The byte {0, segment, mantissa} is XORed with 0xD5 for a non-negative sample or with 0x55 for a negative one. A zero sample gives 0xD5.
- R4: A μ-law magnitude beyond the top segment saturates instead of wrapping: 0x7FFF encodes to 0x80 and 0x8000 encodes to 0x00.
- R5: With the transmit enable high, the code sits in slot bits [SLOT_W-1:SLOT_W-8] and all lower slot bits are 0.
- R6: With the transmit enable low, the slot carries the whole linear sample in its top PCM_W bits, and the remaining low bits are 0.
- R7: With the receive enable high and law select 1, the code byte c is expanded as follows. Let u = ~c. The magnitude is ((u[3:0]·8 + 132) << u[6:4]) − 132. The result is negative when u[7] is 1.
- R8: With the receive enable high and law select 0, the code byte c is expanded as follows. Let a = c XOR 0x55. For segment 0 (a[6:4] = 0) the magnitude is a[3:0]·16 + 8. Otherwise it is (a[3:0]·16 + 264) << (a[6:4] − 1). The result is positive when a[7] is 1.
- R9: With the receive enable high, the 16-bit expanded value occupies output bits [PCM_W-1:PCM_W-16] and the lower bits are 0. Slot bits below the top byte have no effect on the output.
- R10: With the receive enable low, the output equals the top PCM_W bits of the incoming slot.
- R11: An output valid is high exactly one cycle after its input valid. Without an input valid, the output word keeps its previous value.
- R12: The enable and law select are taken per sample and per direction. Back-to-back samples with different settings are each processed under their own settings, and the settings of one direction never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit compression enable |
| tx_law | input | 1 | Transmit law: 0 A-law, 1 μ-law |
| tx_valid | input | 1 | Transmit sample strobe |
| tx_pcm | input | PCM_W | Linear sample, two's complement, MSB-aligned |
| tx_out_valid | output | 1 | Transmit slot valid |
| tx_word | output | SLOT_W | Outgoing audio slot |
| rx_en | input | 1 | Receive expansion enable |
| rx_law | input | 1 | Receive law: 0 A-law, 1 μ-law |
| rx_valid | input | 1 | Receive slot strobe |
| rx_word | input | SLOT_W | Incoming audio slot |
| rx_out_valid | output | 1 | Receive sample valid |
| rx_pcm | output | PCM_W | Expanded linear sample |

## Verification
The clocked properties check the following on every cycle: the one-cycle valid latency and the hold of idle outputs, the zero padding below the transmitted code and below the expanded sample, the transmitted sign bit against the input sign, and μ-law saturation at full positive scale. The exact code values per segment, the two inversion masks, the A-law segment-0 mantissa placement, the expansion of all 256 codes under each law, the pass-through paths, and settings that change between consecutive samples can only be shown by the bench scenarios, which compare against an independently computed scoreboard.

// File: rtl/g711_pkg.sv
package g711_pkg;
  localparam int CODE_W   = 8;
  localparam int ENC_IN_W = 14;
  localparam int DEC_W    = 16;

  typedef enum logic {
    LAW_A  = 1'b0,
    LAW_MU = 1'b1
  } law_e;

  localparam logic [14:0] MU_CLIP      = 15'd8159;
  localparam logic [14:0] MU_BIAS      = 15'd33;
  localparam logic [15:0] MU_DEC_BIAS  = 16'h0084;
  localparam logic [15:0] A_SEG_OFFSET = 16'h0108;
  localparam logic [15:0] A_SEG0_HALF  = 16'h0008;

  localparam logic [CODE_W-1:0] MU_POS_MASK = 8'hFF;
  localparam logic [CODE_W-1:0] MU_NEG_MASK = 8'h7F;
  localparam logic [CODE_W-1:0] A_POS_MASK  = 8'hD5;
  localparam logic [CODE_W-1:0] A_NEG_MASK  = 8'h55;
  localparam logic [CODE_W-1:0] MU_SAT_RAW  = 8'h7F;
endpackage

// File: rtl/g711_compress.sv
module g711_compress
  import g711_pkg::*;
(
  input  logic [ENC_IN_W-1:0] lin_hi,
  input  logic                law_sel,
  output logic [CODE_W-1:0]   code
);
  logic        neg;
  logic [14:0] ext_u;
  logic [14:0] mag_u;
  logic [14:0] bias_u;
  logic        sat_u;
  logic [2:0]  seg_u;
  logic [3:0]  man_u;
  logic [7:0]  raw_u;
  logic [11:0] mag_a;
  logic [2:0]  seg_a;
  logic [3:0]  sh_a;
  logic [3:0]  man_a;
  logic [7:0]  raw_a;

  // mu-law path: 14-bit magnitude, clamp, bias, leading-one segment search
  always_comb begin
    neg    = lin_hi[ENC_IN_W-1];
    ext_u  = {lin_hi[ENC_IN_W-1], lin_hi};
    mag_u  = neg ? (~ext_u + 15'd1) : ext_u;
    if (mag_u > MU_CLIP) mag_u = MU_CLIP;
    bias_u = mag_u + MU_BIAS;
    sat_u  = |bias_u[14:13];
    seg_u  = '0;
    for (int i = 1; i < 8; i++) begin
      if (bias_u[5+i]) seg_u = 3'(i);
    end
    man_u  = 4'(bias_u >> ({1'b0, seg_u} + 4'd1));
    raw_u  = sat_u ? MU_SAT_RAW : {1'b0, seg_u, man_u};
  end

  // A-law path: 13-bit input, ones' complement magnitude, linear segment 0
  always_comb begin
    mag_a = lin_hi[ENC_IN_W-1] ? ~lin_hi[12:1] : lin_hi[12:1];
    seg_a = '0;
    for (int i = 1; i < 8; i++) begin
      if (mag_a[4+i]) seg_a = 3'(i);
    end
    sh_a  = (seg_a < 3'd2) ? 4'd1 : {1'b0, seg_a};
    man_a = 4'(mag_a >> sh_a);
    raw_a = {1'b0, seg_a, man_a};
  end

  always_comb begin
    if (law_sel == LAW_MU) code = raw_u ^ (neg ? MU_NEG_MASK : MU_POS_MASK);
    else                   code = raw_a ^ (neg ? A_NEG_MASK : A_POS_MASK);
  end
endmodule

// File: rtl/g711_expand.sv
module g711_expand
  import g711_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              law_sel,
  output logic [DEC_W-1:0]  lin
);
  logic [7:0]  u;
  logic [15:0] base_u;
  logic [15:0] t_u;
  logic [15:0] lin_u;
  logic [7:0]  a;
  logic [15:0] base_a;
  logic [15:0] t_a;
  logic [15:0] lin_a;

  always_comb begin
    u      = ~code;
    base_u = {9'd0, u[3:0], 3'd0} + MU_DEC_BIAS;
    t_u    = base_u << u[6:4];
    lin_u  = u[7] ? (MU_DEC_BIAS - t_u) : (t_u - MU_DEC_BIAS);
  end

  always_comb begin
    a      = code ^ A_NEG_MASK;
    base_a = {8'd0, a[3:0], 4'd0};
    if (a[6:4] == 3'd0) t_a = base_a + A_SEG0_HALF;
    else                t_a = (base_a + A_SEG_OFFSET) << (a[6:4] - 3'd1);
    lin_a  = a[7] ? t_a : (~t_a + 16'd1);
  end

  always_comb lin = (law_sel == LAW_MU) ? lin_u : lin_a;
endmodule

// File: rtl/g711_codec_stage.sv
module g711_codec_stage
  import g711_pkg::*;
#(
  parameter int PCM_W  = 24,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_law,
  input  logic              tx_valid,
  input  logic [PCM_W-1:0]  tx_pcm,
  output logic              tx_out_valid,
  output logic [SLOT_W-1:0] tx_word,
  input  logic              rx_en,
  input  logic              rx_law,
  input  logic              rx_valid,
  input  logic [SLOT_W-1:0] rx_word,
  output logic              rx_out_valid,
  output logic [PCM_W-1:0]  rx_pcm
);
  localparam int CODE_SH = SLOT_W - CODE_W;
  localparam int BYP_SH  = SLOT_W - PCM_W;
  localparam int EXP_SH  = PCM_W - DEC_W;
  localparam logic [PCM_W-1:0] EXP_LOW_MASK = PCM_W'((64'd1 << EXP_SH) - 64'd1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // transmit direction
  logic [CODE_W-1:0] tx_code;
  logic [SLOT_W-1:0] tx_word_d;
  logic [SLOT_W-1:0] tx_word_q;
  logic              tx_vld_q;

  g711_compress u_comp (
    .lin_hi (tx_pcm[PCM_W-1 -: ENC_IN_W]),
    .law_sel(tx_law),
    .code   (tx_code)
  );

  always_comb begin
    if (tx_en) tx_word_d = SLOT_W'(tx_code) << CODE_SH;
    else       tx_word_d = SLOT_W'(tx_pcm) << BYP_SH;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tx_vld_q  <= 1'b0;
      tx_word_q <= '0;
    end else begin
      tx_vld_q <= tx_valid;
      if (tx_valid) tx_word_q <= tx_word_d;
    end
  end

  assign tx_out_valid = tx_vld_q;
  assign tx_word      = tx_word_q;

  // receive direction
  logic [DEC_W-1:0] rx_lin;
  logic [PCM_W-1:0] rx_pcm_d;
  logic [PCM_W-1:0] rx_pcm_q;
  logic             rx_vld_q;

  g711_expand u_exp (
    .code   (rx_word[SLOT_W-1 -: CODE_W]),
    .law_sel(rx_law),
    .lin    (rx_lin)
  );

  always_comb begin
    if (rx_en) rx_pcm_d = PCM_W'(rx_lin) << EXP_SH;
    else       rx_pcm_d = PCM_W'(rx_word >> BYP_SH);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rx_vld_q <= 1'b0;
      rx_pcm_q <= '0;
    end else begin
      rx_vld_q <= rx_valid;
      if (rx_valid) rx_pcm_q <= rx_pcm_d;
    end
  end

  assign rx_out_valid = rx_vld_q;
  assign rx_pcm       = rx_pcm_q;

  // R11
  tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_q)
    tx_valid |=> tx_out_valid);
  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !tx_valid |=> (!tx_out_valid && $stable(tx_word)));
  // R11
  rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rx_valid |=> rx_out_valid);
  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rx_valid |=> (!rx_out_valid && $stable(rx_pcm)));
  // R2 R3: transmitted sign bit is set for non-negative samples
  tx_sign_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && tx_en) |=> (tx_word[SLOT_W-1] == !$past(tx_pcm[PCM_W-1])));
  // R5
  tx_pad_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && tx_en) |=> (tx_word[CODE_SH-1:0] == '0));
  // R4
  mu_sat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && tx_en && tx_law && tx_pcm[PCM_W-1 -: DEC_W] == 16'h7FFF)
      |=> (tx_word[SLOT_W-1 -: CODE_W] == 8'h80));
  // R9
  rx_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && rx_en) |=> ((rx_pcm & EXP_LOW_MASK) == '0));
endmodule

// File: tb/g711_codec_stage_test.sv
module g711_codec_stage_test;
  localparam int PCM_W  = 24;
  localparam int SLOT_W = 32;

  logic              clk;
  logic              rst_n;
  logic              tx_en, tx_law, tx_valid;
  logic [PCM_W-1:0]  tx_pcm;
  logic              tx_out_valid;
  logic [SLOT_W-1:0] tx_word;
  logic              rx_en, rx_law, rx_valid;
  logic [SLOT_W-1:0] rx_word;
  logic              rx_out_valid;
  logic [PCM_W-1:0]  rx_pcm;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit live = 0;

  logic [SLOT_W-1:0] tx_q[$];
  string             tx_tag[$];
  logic [PCM_W-1:0]  rx_q[$];
  string             rx_tag[$];

  g711_codec_stage #(.PCM_W(PCM_W), .SLOT_W(SLOT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_law(tx_law), .tx_valid(tx_valid), .tx_pcm(tx_pcm),
    .tx_out_valid(tx_out_valid), .tx_word(tx_word),
    .rx_en(rx_en), .rx_law(rx_law), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_out_valid(rx_out_valid), .rx_pcm(rx_pcm)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mu_enc_ref(int s16);
    int x, m, k;
    bit neg;
    x = s16 >>> 2;
    neg = (x < 0);
    m = neg ? -x : x;
    if (m > 8159) m = 8159;
    m = m + 33;
    if (m >= 8192) return neg ? 8'h00 : 8'h80;
    k = 0;
    while (m >= (64 << k)) k++;
    return 8'(((k << 4) | ((m >> (k + 1)) & 15)) ^ (neg ? 8'h7F : 8'hFF));
  endfunction

  function automatic logic [7:0] a_enc_ref(int s16);
    int x, m, k;
    bit neg;
    x = s16 >>> 3;
    neg = (x < 0);
    m = neg ? (-x - 1) : x;
    k = 0;
    while (m >= (32 << k)) k++;
    return 8'(((k << 4) | ((m >> ((k == 0) ? 1 : k)) & 15)) ^ (neg ? 8'h55 : 8'hD5));
  endfunction

  function automatic int mu_dec_ref(int c);
    int u, mag;
    u = (~c) & 255;
    mag = ((((u & 15) << 3) + 132) << ((u >> 4) & 7)) - 132;
    return ((u & 128) != 0) ? -mag : mag;
  endfunction

  function automatic int a_dec_ref(int c);
    int a, e, mag;
    a = c ^ 8'h55;
    e = (a >> 4) & 7;
    mag = (e == 0) ? (((a & 15) << 4) + 8) : ((((a & 15) << 4) + 264) << (e - 1));
    return ((a & 128) != 0) ? mag : -mag;
  endfunction

  task automatic send_tx(input bit en, input bit law, input logic [PCM_W-1:0] p,
                         input logic [SLOT_W-1:0] exp_w, input string tag);
    tx_en = en; tx_law = law; tx_pcm = p; tx_valid = 1'b1;
    tx_q.push_back(exp_w); tx_tag.push_back(tag);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_rx(input bit en, input bit law, input logic [SLOT_W-1:0] w,
                         input logic [PCM_W-1:0] exp_p, input string tag);
    rx_en = en; rx_law = law; rx_word = w; rx_valid = 1'b1;
    rx_q.push_back(exp_p); rx_tag.push_back(tag);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [SLOT_W-1:0] tx_exp_code(logic [7:0] c);
    return {c, 24'h0};
  endfunction

  function automatic logic [PCM_W-1:0] rx_exp_lin(int v);
    return {16'(v), 8'h00};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (live) begin
      if (tx_out_valid) begin
        checks++;
        if (tx_q.size() == 0) begin
          failures++;
          $display("FAIL R11 tx unexpected valid actual=%h expected=none", tx_word);
        end else begin
          logic [SLOT_W-1:0] e;
          string t;
          e = tx_q.pop_front(); t = tx_tag.pop_front();
          if (tx_word !== e) begin
            failures++;
            $display("FAIL %s tx actual=%h expected=%h", t, tx_word, e);
          end
        end
      end
      if (rx_out_valid) begin
        checks++;
        if (rx_q.size() == 0) begin
          failures++;
          $display("FAIL R11 rx unexpected valid actual=%h expected=none", rx_pcm);
        end else begin
          logic [PCM_W-1:0] e;
          string t;
          e = rx_q.pop_front(); t = rx_tag.pop_front();
          if (rx_pcm !== e) begin
            failures++;
            $display("FAIL %s rx actual=%h expected=%h", t, rx_pcm, e);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [SLOT_W-1:0] last_tx;
    logic [PCM_W-1:0]  last_rx;
    rst_n = 0; tx_en = 0; tx_law = 0; tx_valid = 0; tx_pcm = '0;
    rx_en = 0; rx_law = 0; rx_valid = 0; rx_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (tx_out_valid !== 1'b0 || tx_word !== '0 || rx_out_valid !== 1'b0 || rx_pcm !== '0) begin
      failures++;
      $display("FAIL R1 reset actual=%b/%h/%b/%h expected=0/0/0/0",
               tx_out_valid, tx_word, rx_out_valid, rx_pcm);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if (tx_out_valid !== 1'b0 || tx_word !== '0 || rx_out_valid !== 1'b0 || rx_pcm !== '0) begin
      failures++;
      $display("FAIL R1 after release actual=%b/%h/%b/%h expected=0/0/0/0",
               tx_out_valid, tx_word, rx_out_valid, rx_pcm);
    end
    live = 1;

    // anchors
    send_tx(1, 1, 24'h000000, tx_exp_code(8'hFF), "R2 mu zero");
    send_tx(1, 0, 24'h000000, tx_exp_code(8'hD5), "R3 A zero");
    send_tx(1, 1, 24'h7FFFFF, tx_exp_code(8'h80), "R4 mu +full");
    send_tx(1, 1, 24'h800000, tx_exp_code(8'h00), "R4 mu -full");
    send_tx(1, 0, 24'h7FFFFF, tx_exp_code(8'hAA), "R3 A +full");
    send_tx(1, 0, 24'h800000, tx_exp_code(8'h2A), "R3 A -full");
    send_tx(1, 1, 24'hFFFFFF, tx_exp_code(8'h7E), "R2 mu minus one");
    send_tx(1, 0, 24'h001C5A, tx_exp_code(a_enc_ref(16'h001C)), "R3 A seg0 mantissa");
    send_tx(0, 1, 24'hA5C3E1, {24'hA5C3E1, 8'h00}, "R6 bypass");
    send_tx(1, 0, 24'h1234FF, tx_exp_code(a_enc_ref(16'h1234)), "R5 padding");
    // R12: alternating per-sample settings, back to back
    send_tx(1, 1, 24'hC00011, tx_exp_code(mu_enc_ref(-16384)), "R12 mu");
    send_tx(1, 0, 24'hC00011, tx_exp_code(a_enc_ref(-16384)), "R12 A");
    send_tx(0, 0, 24'hC00011, {24'hC00011, 8'h00}, "R12 bypass");
    last_tx = {24'hC00011, 8'h00};
    repeat (3) @(negedge clk);
    // R11: output held while idle
    checks++;
    if (tx_out_valid !== 1'b0 || tx_word !== last_tx) begin
      failures++;
      $display("FAIL R11 tx hold actual=%b/%h expected=0/%h", tx_out_valid, tx_word, last_tx);
    end

    // sweeps
    for (int s = -32768; s < 32768; s += 97) begin
      send_tx(1, 1, {16'(s), 8'(s * 7)}, tx_exp_code(mu_enc_ref(s)), "R2 mu sweep");
    end
    for (int s = -32768; s < 32768; s += 89) begin
      send_tx(1, 0, {16'(s), 8'(s * 3)}, tx_exp_code(a_enc_ref(s)), "R3 A sweep");
    end
    @(negedge clk);

    // receive anchors
    send_rx(1, 1, 32'hFF000000, rx_exp_lin(0), "R7 mu 0xFF");
    send_rx(1, 1, 32'h80000000, rx_exp_lin(32124), "R7 mu 0x80");
    send_rx(1, 0, 32'hD5000000, rx_exp_lin(8), "R8 A 0xD5");
    send_rx(1, 0, 32'h55000000, rx_exp_lin(-8), "R8 A 0x55");
    send_rx(1, 0, 32'hD5ABCDEF, rx_exp_lin(8), "R9 low slot bits ignored");
    send_rx(0, 1, 32'h12345678, 24'h123456, "R10 bypass");
    // R12: both directions concurrently with different settings
    fork
      send_tx(1, 1, 24'h040000, tx_exp_code(mu_enc_ref(16'h0400)), "R12 tx during rx");
      send_rx(1, 0, 32'h9A000000, rx_exp_lin(a_dec_ref(8'h9A)), "R12 rx during tx");
    join
    send_rx(1, 1, 32'h9A000000, rx_exp_lin(mu_dec_ref(8'h9A)), "R12 rx law switch");
    last_rx = rx_exp_lin(mu_dec_ref(8'h9A));
    repeat (3) @(negedge clk);
    checks++;
    if (rx_out_valid !== 1'b0 || rx_pcm !== last_rx) begin
      failures++;
      $display("FAIL R11 rx hold actual=%b/%h expected=0/%h", rx_out_valid, rx_pcm, last_rx);
    end

    for (int c = 0; c < 256; c++) begin
      send_rx(1, 1, {8'(c), 24'(c * 4099)}, rx_exp_lin(mu_dec_ref(c)), "R7 mu all codes");
    end
    for (int c = 0; c < 256; c++) begin
      send_rx(1, 0, {8'(c), 24'(c * 577)}, rx_exp_lin(a_dec_ref(c)), "R8 A all codes");
    end
    repeat (3) @(negedge clk);

    checks++;
    if (tx_q.size() != 0 || rx_q.size() != 0) begin
      failures++;
      $display("FAIL R11 missing outputs actual=%0d/%0d expected=0/0", tx_q.size(), rx_q.size());
    end
    finish_run();
  end
endmodule